// File: doc/BRIEF.md
# Return Address Stack with Interrupt Hold

This block holds subroutine return addresses for a small processor core. It has six levels, and each level holds one 12-bit program counter value. Software can neither read nor write the levels or the pointer that selects them. The sequencer raises `call_i` for a subroutine call and `ret_i` for either kind of return. It presents the address to save on `push_pc_i` and finds the address to resume at on `ret_addr_o`. The block also takes part in interrupt entry. A request on `irq_req_i` is latched until it is taken. The block grants it on `irq_ack_o` only when there is a free level to hold the interrupted program counter. In the grant cycle, the address on `push_pc_i` is saved.

The levels form a ring, and a separate count of 0 to 6 tracks how many are occupied. A call made with all six levels occupied does not stop or fault. It overwrites the oldest level, so the six most recent addresses remain. The command pins are single-cycle strobes with no handshake and no back-pressure. Every command is accepted in the cycle it is presented. The only flow control is the interrupt grant, which waits for a free level.

Top module: `ret_stack_irq`

## Requirements
- R1: After reset, `empty_o` is 1, `full_o` is 0, `irq_ack_o` is 0 and `ret_addr_o` is 0.
- R2: A cycle with `call_i`=1 saves `push_pc_i`. From the next cycle `ret_addr_o` shows that value, and the depth grows by one if it was below 6.
- R3: A cycle with `ret_i`=1, `call_i`=0 and depth above 0 removes the top level. From the next cycle `ret_addr_o` shows the level below it, so addresses come back in last-in, first-out order.
- R4: `full_o` is 1 exactly when six levels are occupied, and the depth never exceeds 6.
- R5: A call made while full keeps `full_o` at 1 and discards the oldest address. Six returns after seven calls hand back the last six addresses, newest first, and then leave the stack empty.
- R6: A return while empty changes nothing: `empty_o` stays 1 and `ret_addr_o` keeps its value.
- R7: An interrupt request is latched. With `irq_en_i`=1, the stack not full and neither `call_i` nor `ret_i` asserted, `irq_ack_o` is 1 in that same cycle, and `push_pc_i` is saved as in R2.
- R8: While full, `irq_ack_o` stays 0 and the request stays latched. In the return cycle the grant is still withheld. In the cycle after a return has freed a level, the grant is given.
- R9: When `call_i` and an interrupt are both present in a cycle, only the call is served. The interrupt is granted in the next cycle in which R7 holds.
- R10: With `irq_en_i`=0 a request is latched but not granted. It is granted once the enable is raised.
- R11: When `call_i` and `ret_i` are both 1, the call is performed and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| call_i | input | 1 | Subroutine call strobe, pushes `push_pc_i` |
| ret_i | input | 1 | Return strobe, pops the top level |
| irq_req_i | input | 1 | Interrupt request pulse or level, latched |
| irq_en_i | input | 1 | Global interrupt enable |
| push_pc_i | input | 12 | Program counter value to save |
| ret_addr_o | output | 12 | Address in the top level |
| irq_ack_o | output | 1 | Interrupt grant; a push happens in the same cycle |
| full_o | output | 1 | All six levels occupied |
| empty_o | output | 1 | No level occupied |

## Verification
The assertions check the following on every cycle:
- the depth stays within its bound;
- a grant never coincides with a full stack or with a call;
- a held request is not lost;
- a push shows its address at the top on the next cycle;
- pushes and pops at the limits leave the depth where the requirements put it.

Only the bench scenarios can show the ordering properties, because these need histories longer than any single property:
- that seven calls drop exactly the oldest address;
- that addresses return newest first;
- that a request held while full is granted in the cycle after a return and not in the return cycle itself.

// File: rtl/ret_stack_irq_pkg.sv
package ret_stack_irq_pkg;

  // Operation applied to the ring in one cycle
  typedef enum logic [1:0] {
    STK_IDLE = 2'd0,
    STK_PUSH = 2'd1,
    STK_POP  = 2'd2
  } stk_op_e;

endpackage

// File: rtl/rsi_irq_gate.sv
module rsi_irq_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_req_i,
  input  logic irq_en_i,
  input  logic full_i,
  input  logic call_i,
  input  logic ret_i,
  output logic ack_o
);

  logic pend_q;
  logic pend_any;

  // A request is live if it was latched earlier or arrives in this cycle
  assign pend_any = pend_q | irq_req_i;

  // Grant only when a level is free and no call or return owns the cycle
  assign ack_o = pend_any & irq_en_i & ~full_i & ~call_i & ~ret_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_any & ~ack_o;
  end

  assert_no_ack_when_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    full_i |-> !ack_o);

  assert_call_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    call_i |-> !ack_o);

  assert_pending_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_any && !ack_o) |=> pend_q);

  assert_no_ack_disabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en_i |-> !ack_o);

endmodule

// File: rtl/rsi_ptr.sv
module rsi_ptr #(
  parameter int DEPTH = 6,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  ret_stack_irq_pkg::stk_op_e    op_i,
  output logic [IW-1:0]                 wr_idx_o,
  output logic [IW-1:0]                 top_idx_o,
  output logic                          full_o,
  output logic                          empty_o
);
  import ret_stack_irq_pkg::*;

  localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);
  localparam logic [CW-1:0] MAX_CNT  = CW'(DEPTH);

  logic [IW-1:0] wr_q;
  logic [CW-1:0] cnt_q;
  logic [IW-1:0] wr_next_up;
  logic [IW-1:0] wr_next_dn;

  assign wr_next_up = (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
  assign wr_next_dn = (wr_q == '0) ? LAST_IDX : wr_q - 1'b1;

  assign wr_idx_o  = wr_q;
  assign top_idx_o = wr_next_dn;
  assign full_o    = (cnt_q == MAX_CNT);
  assign empty_o   = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      unique case (op_i)
        STK_PUSH: begin
          // Ring always advances; the count saturates so the oldest level is overwritten
          wr_q <= wr_next_up;
          if (cnt_q != MAX_CNT) cnt_q <= cnt_q + 1'b1;
        end
        STK_POP: begin
          // Pop from an empty ring leaves everything untouched
          if (cnt_q != '0) begin
            wr_q  <= wr_next_dn;
            cnt_q <= cnt_q - 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assert_count_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= MAX_CNT);

  assert_push_grows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == STK_PUSH && !full_o) |=> (cnt_q == $past(cnt_q) + 1'b1));

  assert_overflow_stays_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == STK_PUSH && full_o) |=> full_o);

  assert_empty_pop_inert_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == STK_POP && empty_o) |=> (empty_o && $stable(wr_q)));

  assert_pop_shrinks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == STK_POP && !empty_o) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rsi_storage.sv
module rsi_storage #(
  parameter int DEPTH = 6,
  parameter int AW    = 12,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [AW-1:0] rd_data_o
);

  logic [AW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot_q[g] <= '0;
      else if (we_i && wr_idx_i == IW'(g))         slot_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = slot_q[rd_idx_i];

endmodule

// File: rtl/ret_stack_irq.sv
module ret_stack_irq #(
  parameter int DEPTH = 6,
  parameter int AW    = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          call_i,
  input  logic          ret_i,
  input  logic          irq_req_i,
  input  logic          irq_en_i,
  input  logic [AW-1:0] push_pc_i,
  output logic [AW-1:0] ret_addr_o,
  output logic          irq_ack_o,
  output logic          full_o,
  output logic          empty_o
);
  import ret_stack_irq_pkg::*;

  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  stk_op_e       op;
  logic [IW-1:0] wr_idx;
  logic [IW-1:0] top_idx;
  logic          ack;

  // Call outranks interrupt and return; a grant never shares a cycle with a return
  always_comb begin
    if (call_i || ack) op = STK_PUSH;
    else if (ret_i)    op = STK_POP;
    else               op = STK_IDLE;
  end

  rsi_irq_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req_i (irq_req_i),
    .irq_en_i  (irq_en_i),
    .full_i    (full_o),
    .call_i    (call_i),
    .ret_i     (ret_i),
    .ack_o     (ack)
  );

  rsi_ptr #(.DEPTH(DEPTH)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_i      (op),
    .wr_idx_o  (wr_idx),
    .top_idx_o (top_idx),
    .full_o    (full_o),
    .empty_o   (empty_o)
  );

  rsi_storage #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .we_i      (op == STK_PUSH),
    .wr_idx_i  (wr_idx),
    .wr_data_i (push_pc_i),
    .rd_idx_i  (top_idx),
    .rd_data_o (ret_addr_o)
  );

  assign irq_ack_o = ack;

  assert_push_on_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i || irq_ack_o) |=> (ret_addr_o == $past(push_pc_i)));

  assert_call_beats_ret_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (call_i && ret_i) |=> !empty_o);

  assert_flags_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(full_o && empty_o));

endmodule

// File: tb/ret_stack_irq_tb.sv
module ret_stack_irq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        call_i = 1'b0, ret_i = 1'b0, irq_req_i = 1'b0, irq_en_i = 1'b0;
  logic [11:0] push_pc_i = '0;
  logic [11:0] ret_addr_o;
  logic        irq_ack_o, full_o, empty_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ret_stack_irq u_dut (
    .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
    .irq_req_i(irq_req_i), .irq_en_i(irq_en_i), .push_pc_i(push_pc_i),
    .ret_addr_o(ret_addr_o), .irq_ack_o(irq_ack_o), .full_o(full_o), .empty_o(empty_o)
  );

  // {call, ret, irq, en, pc, exp_ack, exp_empty, exp_full, exp_top}
  typedef struct packed {
    logic        call;
    logic        ret;
    logic        irq;
    logic        en;
    logic [11:0] pc;
    logic        ack;
    logic        emp;
    logic        ful;
    logic [11:0] top;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b1,1'b0,1'b0,1'b0,12'h100, 1'b0,1'b0,1'b0,12'h100}, // R2 call
    '{1'b1,1'b0,1'b0,1'b0,12'h200, 1'b0,1'b0,1'b0,12'h200}, // R2 call
    '{1'b0,1'b1,1'b0,1'b0,12'h000, 1'b0,1'b0,1'b0,12'h100}, // R3 pop
    '{1'b0,1'b0,1'b1,1'b1,12'h300, 1'b1,1'b0,1'b0,12'h300}, // R7 grant pushes
    '{1'b0,1'b1,1'b0,1'b0,12'h000, 1'b0,1'b0,1'b0,12'h100}, // R3 pop
    '{1'b0,1'b1,1'b0,1'b0,12'h000, 1'b0,1'b1,1'b0,12'h000}, // R3 to empty
    '{1'b0,1'b1,1'b0,1'b0,12'h000, 1'b0,1'b1,1'b0,12'h000}, // R6 empty pop
    '{1'b0,1'b0,1'b1,1'b0,12'h111, 1'b0,1'b1,1'b0,12'h000}, // R10 latched, disabled
    '{1'b0,1'b0,1'b0,1'b0,12'h000, 1'b0,1'b1,1'b0,12'h000}, // R10 still held
    '{1'b0,1'b0,1'b0,1'b1,12'h222, 1'b1,1'b0,1'b0,12'h222}, // R10 enable grants
    '{1'b1,1'b1,1'b0,1'b0,12'h333, 1'b0,1'b0,1'b0,12'h333}, // R11 call wins
    '{1'b0,1'b1,1'b0,1'b0,12'h000, 1'b0,1'b0,1'b0,12'h222}  // R11 depth was two
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive at falling edge, check grant mid-cycle, check state after rising edge
  task automatic step(input logic c, input logic r, input logic q, input logic e,
                      input logic [11:0] pc, input logic x_ack, input logic x_emp,
                      input logic x_ful, input bit chk_top, input logic [11:0] x_top,
                      input string req);
    @(negedge clk);
    call_i = c; ret_i = r; irq_req_i = q; irq_en_i = e; push_pc_i = pc;
    #1;
    check(irq_ack_o == x_ack, req, 32'(irq_ack_o), 32'(x_ack));
    @(posedge clk);
    #1;
    check({empty_o, full_o} == {x_emp, x_ful}, req, 32'({empty_o, full_o}), 32'({x_emp, x_ful}));
    if (chk_top) check(ret_addr_o == x_top, req, 32'(ret_addr_o), 32'(x_top));
  endtask

  task automatic do_reset();
    @(negedge clk);
    call_i = 0; ret_i = 0; irq_req_i = 0; irq_en_i = 0; push_pc_i = '0;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    #(CLK_PERIOD * 2 + 1);
    check(empty_o == 1'b1, "R1", 32'(empty_o), 32'd1);
    check(full_o == 1'b0, "R1", 32'(full_o), 32'd0);
    check(irq_ack_o == 1'b0, "R1", 32'(irq_ack_o), 32'd0);
    check(ret_addr_o == 12'h0, "R1", 32'(ret_addr_o), 32'd0);
    do_reset();

    for (int i = 0; i < NVEC; i++)
      step(VECS[i].call, VECS[i].ret, VECS[i].irq, VECS[i].en, VECS[i].pc,
           VECS[i].ack, VECS[i].emp, VECS[i].ful, 1'b1, VECS[i].top, $sformatf("vec%0d", i));

    // R4 and R5: seven calls, oldest dropped
    do_reset();
    for (int i = 1; i <= 7; i++)
      step(1, 0, 0, 0, 12'hA00 + 12'(i), 0, 0, (i >= 6), 1, 12'hA00 + 12'(i), "R4_R5 fill");
    for (int i = 7; i >= 3; i--)
      step(0, 1, 0, 0, 12'h000, 0, 0, 0, 1, 12'hA00 + 12'(i - 1), "R5 unwind");
    step(0, 1, 0, 0, 12'h000, 0, 1, 0, 0, 12'h000, "R5 sixth pop empties");

    // R8: request held while full, granted after a return
    do_reset();
    for (int i = 1; i <= 6; i++)
      step(1, 0, 0, 0, 12'hB00 + 12'(i), 0, 0, (i == 6), 1, 12'hB00 + 12'(i), "R8 fill");
    step(0, 0, 1, 1, 12'hBAD, 0, 0, 1, 1, 12'hB06, "R8 held while full");
    step(0, 0, 0, 1, 12'hBAD, 0, 0, 1, 1, 12'hB06, "R8 still held");
    step(0, 1, 0, 1, 12'hBAD, 0, 0, 0, 1, 12'hB05, "R8 no grant in return cycle");
    step(0, 0, 0, 1, 12'hBEE, 1, 0, 1, 1, 12'hBEE, "R8 granted after return");

    // R9: call and interrupt together
    do_reset();
    step(1, 0, 1, 1, 12'h0C1, 0, 0, 0, 1, 12'h0C1, "R9 call served first");
    step(0, 0, 0, 1, 12'h0C2, 1, 0, 0, 1, 12'h0C2, "R9 grant next cycle");
    step(0, 1, 0, 0, 12'h000, 0, 0, 0, 1, 12'h0C1, "R9 order");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule